// File: doc/BRIEF.md
# Iterative multiply/divide unit with result-register interlock

This block performs 32-bit integer multiplication and division next to a RISC core's issue stage. It keeps two result registers of its own, an upper word and a lower word. A multiply leaves the 64-bit product split across them. A divide leaves the quotient in the lower word and the remainder in the upper word. Both operations come in signed and unsigned forms. The multiplier retires a configurable number of multiplier bits per cycle. The divider uses restoring division and produces one quotient bit per cycle.

The core presents a request each cycle: a valid flag, a 6-bit function code and two source words. Requests whose function code does not concern the unit are ignored and never held back, so unrelated instructions keep flowing while an operation runs. Any request that touches the result registers is stalled only while an operation is in flight. This covers a start, a read or a write. A read returns its data in the cycle it is accepted. Overflow is never flagged. A zero divisor produces no error and leaves unspecified values in the result registers.

Top module: `muldiv_unit`

## Requirements
- R1: Function 011000 multiplies the sources as two's complement numbers and 011001 multiplies them as unsigned numbers; the low 32 bits of the product go to the lower register and the high 32 bits go to the upper register.
- R2: Function 011010 divides as two's complement and 011011 divides as unsigned; the quotient goes to the lower register and the remainder to the upper register. A signed quotient truncates toward zero and a signed remainder takes the sign of the dividend.
- R3: A zero divisor takes the normal divide latency and raises no error, and the unit then accepts and completes further work correctly.
- R4: Signed wrap cases raise nothing and keep the low 32 bits of the result: 0x80000000 divided by 0xFFFFFFFF gives lower 0x80000000 and upper 0; 0x80000000 times 0xFFFFFFFF gives lower 0x80000000 and upper 0.
- R5: `busy` rises in the cycle after a start is accepted. It stays high for exactly 8 cycles for a multiply and 32 for a divide. The result registers change on the same edge at which `busy` falls.
- R6: A read (010000 upper, 010010 lower) while `busy` is high raises `req_stall` and keeps `rd_valid` low. Once `busy` is low, the read is accepted in that cycle with `rd_valid` high and `rd_data` holding the new result.
- R7: A multiply or divide request while `busy` is high is stalled and not started, and the operation in flight finishes with unchanged latency and result.
- R8: A write (010001 upper, 010011 lower) copies `req_src_a` into only its target register, visible from the next cycle. While `busy` is high it stalls, then applies after the operation completes.
- R9: Any other function code never raises `req_stall` and changes neither the result registers nor `busy`, even while an operation is in flight.
- R10: After reset `busy` is low and both result registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_func | input | 6 | Function code of the request |
| req_src_a | input | 32 | First source (dividend, multiplicand, or data for a write) |
| req_src_b | input | 32 | Second source (divisor or multiplier) |
| req_stall | output | 1 | Request touches the result registers while an operation is in flight |
| busy | output | 1 | Operation in flight |
| rd_valid | output | 1 | A read is accepted this cycle |
| rd_data | output | 32 | Data of the accepted read, zero otherwise |

## Verification
`req_stall`, `rd_valid` and `rd_data` are combinational, so they are due in the same cycle the request is driven. `busy` is due one edge after an accepted start. A multiply result is due 8 edges after acceptance and a divide result 32 edges after, and a write is visible from the next cycle. Inputs change on the falling edge. The outputs are compared 1 ns later against a behavioural model that advances on the rising edge, so each check lands in the cycle where the value is due. Dedicated checks also count the high cycles of `busy` and read both registers back with hand-computed constants.

// File: rtl/muldiv_pkg.sv
// Shared function codes, request classification and decode for the
// multiply/divide unit. Assumes a 6-bit function field.
package muldiv_pkg;

    localparam logic [5:0] FN_RD_UP  = 6'b010000;
    localparam logic [5:0] FN_WR_UP  = 6'b010001;
    localparam logic [5:0] FN_RD_LO  = 6'b010010;
    localparam logic [5:0] FN_WR_LO  = 6'b010011;
    localparam logic [5:0] FN_MUL_S  = 6'b011000;
    localparam logic [5:0] FN_MUL_U  = 6'b011001;
    localparam logic [5:0] FN_DIV_S  = 6'b011010;
    localparam logic [5:0] FN_DIV_U  = 6'b011011;

    typedef enum logic [2:0] {
        K_NONE,
        K_MUL,
        K_DIV,
        K_READ,
        K_WRITE
    } md_kind_e;

    typedef struct packed {
        md_kind_e kind;
        logic     is_signed;
        logic     sel_upper;
    } md_cmd_t;

    // Classify a function code into the action the unit takes
    function automatic md_cmd_t md_decode(input logic [5:0] fn);
        md_cmd_t c;
        c.kind      = K_NONE;
        c.is_signed = 1'b0;
        c.sel_upper = 1'b0;
        case (fn)
            FN_MUL_S: begin c.kind = K_MUL;   c.is_signed = 1'b1; end
            FN_MUL_U: begin c.kind = K_MUL;   end
            FN_DIV_S: begin c.kind = K_DIV;   c.is_signed = 1'b1; end
            FN_DIV_U: begin c.kind = K_DIV;   end
            FN_RD_UP: begin c.kind = K_READ;  c.sel_upper = 1'b1; end
            FN_RD_LO: begin c.kind = K_READ;  end
            FN_WR_UP: begin c.kind = K_WRITE; c.sel_upper = 1'b1; end
            FN_WR_LO: begin c.kind = K_WRITE; end
            default:  c.kind = K_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/muldiv_mul_iter.sv
// Iterative shift-add multiplier. Works on operand magnitudes and
// retires STEP_BITS multiplier bits per cycle, then negates the 64-bit
// product if the signed operands differ in sign. Assumes WIDTH is a
// multiple of STEP_BITS and that start is only pulsed while idle.
module muldiv_mul_iter #(
    parameter int WIDTH     = 32,
    parameter int STEP_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             fin,
    output logic [WIDTH-1:0] res_upper,
    output logic [WIDTH-1:0] res_lower
);
    localparam int STEPS = WIDTH / STEP_BITS;
    localparam int CW    = $clog2(STEPS + 1);
    localparam int PW    = 2 * WIDTH;

    logic [PW-1:0]    acc_q;
    logic [PW-1:0]    mcand_q;
    logic [WIDTH-1:0] mplier_q;
    logic             neg_q;
    logic [CW-1:0]    cnt_q;
    logic             active_q;

    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic [PW-1:0]    pp [STEP_BITS];
    logic [PW-1:0]    step_sum;
    logic [PW-1:0]    acc_nxt;
    logic [PW-1:0]    prod;

    // Operand magnitudes for the signed forms
    always_comb begin
        mag_a = (is_signed && op_a[WIDTH-1]) ? (~op_a + 1'b1) : op_a;
        mag_b = (is_signed && op_b[WIDTH-1]) ? (~op_b + 1'b1) : op_b;
    end

    // One shifted partial product per retired multiplier bit
    for (genvar j = 0; j < STEP_BITS; j++) begin : g_pp
        assign pp[j] = mplier_q[j] ? (mcand_q << j) : '0;
    end

    // Sum the partial products of this step into the accumulator
    always_comb begin
        step_sum = '0;
        for (int j = 0; j < STEP_BITS; j++) begin
            step_sum = step_sum + pp[j];
        end
        acc_nxt = acc_q + step_sum;
        prod    = neg_q ? (~acc_nxt + 1'b1) : acc_nxt;
    end

    assign busy      = active_q;
    assign fin       = active_q && (cnt_q == CW'(1));
    assign res_upper = prod[PW-1:WIDTH];
    assign res_lower = prod[WIDTH-1:0];

    // Load operands on start, then advance one step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            neg_q    <= 1'b0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            acc_q    <= '0;
            mcand_q  <= {{WIDTH{1'b0}}, mag_a};
            mplier_q <= mag_b;
            neg_q    <= is_signed && (op_a[WIDTH-1] ^ op_b[WIDTH-1]);
            cnt_q    <= CW'(STEPS);
            active_q <= 1'b1;
        end else if (active_q) begin
            acc_q    <= acc_nxt;
            mcand_q  <= mcand_q << STEP_BITS;
            mplier_q <= mplier_q >> STEP_BITS;
            cnt_q    <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                active_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/muldiv_div_iter.sv
// Restoring divider, one quotient bit per cycle over WIDTH cycles.
// Divides magnitudes, then negates the quotient when the signs differ
// and gives the remainder the dividend's sign. A zero divisor simply
// runs to completion. Assumes start is only pulsed while idle.
module muldiv_div_iter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             fin,
    output logic [WIDTH-1:0] res_upper,
    output logic [WIDTH-1:0] res_lower
);
    localparam int STEPS = WIDTH;
    localparam int CW    = $clog2(STEPS + 1);

    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] dvsr_q;
    logic             negq_q;
    logic             negr_q;
    logic [CW-1:0]    cnt_q;
    logic             active_q;

    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic [WIDTH:0]   shifted;
    logic [WIDTH:0]   diff;
    logic             fits;
    logic [WIDTH-1:0] rem_nxt;
    logic [WIDTH-1:0] quo_nxt;

    // Operand magnitudes for the signed forms
    always_comb begin
        mag_a = (is_signed && op_a[WIDTH-1]) ? (~op_a + 1'b1) : op_a;
        mag_b = (is_signed && op_b[WIDTH-1]) ? (~op_b + 1'b1) : op_b;
    end

    // Trial subtraction of one restoring step
    always_comb begin
        shifted = {rem_q, quo_q[WIDTH-1]};
        diff    = shifted - {1'b0, dvsr_q};
        fits    = !diff[WIDTH];
        rem_nxt = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
        quo_nxt = {quo_q[WIDTH-2:0], fits};
    end

    assign busy      = active_q;
    assign fin       = active_q && (cnt_q == CW'(1));
    assign res_lower = negq_q ? (~quo_nxt + 1'b1) : quo_nxt;
    assign res_upper = negr_q ? (~rem_nxt + 1'b1) : rem_nxt;

    // Load operands on start, then shift in one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            quo_q    <= '0;
            dvsr_q   <= '0;
            negq_q   <= 1'b0;
            negr_q   <= 1'b0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            rem_q    <= '0;
            quo_q    <= mag_a;
            dvsr_q   <= mag_b;
            negq_q   <= is_signed && (op_a[WIDTH-1] ^ op_b[WIDTH-1]);
            negr_q   <= is_signed && op_a[WIDTH-1];
            cnt_q    <= CW'(STEPS);
            active_q <= 1'b1;
        end else if (active_q) begin
            rem_q <= rem_nxt;
            quo_q <= quo_nxt;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                active_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/muldiv_resreg.sv
// Upper and lower result registers. An engine completion writes both
// words. A direct write touches only its own word. The engine takes
// priority, although the interlock keeps the two from coinciding.
module muldiv_resreg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_we,
    input  logic [WIDTH-1:0] eng_upper,
    input  logic [WIDTH-1:0] eng_lower,
    input  logic             wr_upper,
    input  logic             wr_lower,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] upper_q,
    output logic [WIDTH-1:0] lower_q
);
    // Capture engine results or a single-word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
        end else if (eng_we) begin
            upper_q <= eng_upper;
            lower_q <= eng_lower;
        end else begin
            if (wr_upper) upper_q <= wr_data;
            if (wr_lower) lower_q <= wr_data;
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
// Multiply/divide unit top. Decodes each request and stalls only the
// requests that touch the result registers while an engine is running.
// It starts the multiplier or divider, serves reads combinationally and
// commits engine results. Assumes the core holds a stalled request.
module muldiv_unit #(
    parameter int WIDTH         = 32,
    parameter int MUL_STEP_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [5:0]       req_func,
    input  logic [WIDTH-1:0] req_src_a,
    input  logic [WIDTH-1:0] req_src_b,
    output logic             req_stall,
    output logic             busy,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    import muldiv_pkg::*;

    md_cmd_t          cmd;
    logic             accept;
    logic             mul_start;
    logic             div_start;
    logic             mul_busy, div_busy;
    logic             mul_fin, div_fin;
    logic [WIDTH-1:0] mul_up, mul_lo, div_up, div_lo;
    logic             res_we;
    logic [WIDTH-1:0] res_up, res_lo;
    logic [WIDTH-1:0] upper_q, lower_q;

    // Request decode, interlock and start strobes
    always_comb begin
        cmd       = md_decode(req_func);
        req_stall = req_valid && (cmd.kind != K_NONE) && busy;
        accept    = req_valid && !req_stall;
        mul_start = accept && (cmd.kind == K_MUL);
        div_start = accept && (cmd.kind == K_DIV);
    end

    muldiv_mul_iter #(
        .WIDTH     (WIDTH),
        .STEP_BITS (MUL_STEP_BITS)
    ) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mul_start),
        .is_signed (cmd.is_signed),
        .op_a      (req_src_a),
        .op_b      (req_src_b),
        .busy      (mul_busy),
        .fin       (mul_fin),
        .res_upper (mul_up),
        .res_lower (mul_lo)
    );

    muldiv_div_iter #(
        .WIDTH (WIDTH)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .is_signed (cmd.is_signed),
        .op_a      (req_src_a),
        .op_b      (req_src_b),
        .busy      (div_busy),
        .fin       (div_fin),
        .res_upper (div_up),
        .res_lower (div_lo)
    );

    // Select the finishing engine's result
    always_comb begin
        busy   = mul_busy || div_busy;
        res_we = mul_fin || div_fin;
        res_up = div_fin ? div_up : mul_up;
        res_lo = div_fin ? div_lo : mul_lo;
    end

    muldiv_resreg #(
        .WIDTH (WIDTH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_we    (res_we),
        .eng_upper (res_up),
        .eng_lower (res_lo),
        .wr_upper  (accept && (cmd.kind == K_WRITE) && cmd.sel_upper),
        .wr_lower  (accept && (cmd.kind == K_WRITE) && !cmd.sel_upper),
        .wr_data   (req_src_a),
        .upper_q   (upper_q),
        .lower_q   (lower_q)
    );

    // Serve an accepted read in the same cycle
    always_comb begin
        rd_valid = accept && (cmd.kind == K_READ);
        rd_data  = rd_valid ? (cmd.sel_upper ? upper_q : lower_q) : '0;
    end

endmodule

// File: rtl/muldiv_unit_chk.sv
// Property checker for muldiv_unit, attached by bind. It watches the
// start strobes, the commit strobe and the result registers, and counts
// busy cycles to check the latency of each operation.
module muldiv_unit_chk #(
    parameter int WIDTH     = 32,
    parameter int MUL_STEPS = 8,
    parameter int DIV_STEPS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mul_start,
    input logic             div_start,
    input logic             busy,
    input logic             res_we,
    input logic             req_stall,
    input logic             rd_valid,
    input logic [WIDTH-1:0] upper_q,
    input logic [WIDTH-1:0] lower_q
);
    logic [15:0] lat_q;
    logic        div_q;

    // Count busy cycles since the last accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            div_q <= 1'b0;
        end else if (mul_start || div_start) begin
            lat_q <= '0;
            div_q <= div_start;
        end else if (busy && !res_we) begin
            lat_q <= lat_q + 16'd1;
        end
    end

    assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_start || div_start) |=> busy);

    assert_busy_holds_until_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_we) |=> busy);

    assert_commit_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (busy && (lat_q == (div_q ? 16'(DIV_STEPS - 1) : 16'(MUL_STEPS - 1)))));

    assert_regs_hold_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_we) |=> ($stable(upper_q) && $stable(lower_q)));

    assert_no_start_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(mul_start || div_start));

    assert_read_only_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

    assert_stall_only_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_stall |-> busy);

endmodule

bind muldiv_unit muldiv_unit_chk #(
    .WIDTH     (WIDTH),
    .MUL_STEPS (WIDTH / MUL_STEP_BITS),
    .DIV_STEPS (WIDTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mul_start (mul_start),
    .div_start (div_start),
    .busy      (busy),
    .res_we    (res_we),
    .req_stall (req_stall),
    .rd_valid  (rd_valid),
    .upper_q   (upper_q),
    .lower_q   (lower_q)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
    localparam logic [5:0] RU = 6'b010000, WU = 6'b010001, RL = 6'b010010, WL = 6'b010011;
    localparam logic [5:0] MS = 6'b011000, MU = 6'b011001, DS = 6'b011010, DU = 6'b011011;
    localparam int MUL_LAT = 8;
    localparam int DIV_LAT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_func = 6'b0;
    logic [31:0] req_a = '0;
    logic [31:0] req_b = '0;
    logic        req_stall, busy, rd_valid;
    logic [31:0] rd_data;

    int    n_checks = 0;
    int    n_err = 0;
    string cur_tag = "R10";

    // Behavioural reference state
    logic        m_busy = 1'b0;
    int          m_cnt = 0;
    logic [31:0] m_up = '0, m_lo = '0, p_up = '0, p_lo = '0;
    logic        m_uup = 1'b0, m_ulo = 1'b0, p_undef = 1'b0;

    always #2 clk = ~clk;

    muldiv_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_func  (req_func),
        .req_src_a (req_a),
        .req_src_b (req_b),
        .req_stall (req_stall),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    function automatic logic touches(input logic [5:0] f);
        return f inside {RU, WU, RL, WL, MS, MU, DS, DU};
    endfunction

    // Reference model: advances on each rising edge
    always @(posedge clk) begin
        logic   old_busy;
        longint pa, pb, pr, pq;
        if (!rst_n) begin
            m_busy = 1'b0; m_cnt = 0; m_up = '0; m_lo = '0; m_uup = 1'b0; m_ulo = 1'b0;
        end else begin
            old_busy = m_busy;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 1'b0; m_up = p_up; m_lo = p_lo; m_uup = p_undef; m_ulo = p_undef;
                end
            end
            if (req_valid && !(touches(req_func) && old_busy)) begin
                if (req_func == MS || req_func == DS) begin
                    pa = longint'($signed(req_a)); pb = longint'($signed(req_b));
                end else begin
                    pa = longint'({32'b0, req_a}); pb = longint'({32'b0, req_b});
                end
                case (req_func)
                    MS, MU: begin
                        pr = pa * pb;
                        p_up = pr[63:32]; p_lo = pr[31:0]; p_undef = 1'b0;
                        m_busy = 1'b1; m_cnt = MUL_LAT;
                    end
                    DS, DU: begin
                        if (pb == 0) begin
                            p_undef = 1'b1; p_up = '0; p_lo = '0;
                        end else begin
                            pq = pa / pb; pr = pa % pb;
                            p_lo = pq[31:0]; p_up = pr[31:0]; p_undef = 1'b0;
                        end
                        m_busy = 1'b1; m_cnt = DIV_LAT;
                    end
                    WU: begin m_up = req_a; m_uup = 1'b0; end
                    WL: begin m_lo = req_a; m_ulo = 1'b0; end
                    default: ;
                endcase
            end
        end
    end

    task automatic check_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs and compare every output with the model
    task automatic cyc(input logic v, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        logic        e_stall, e_rv, skip;
        logic [31:0] e_data;
        @(negedge clk);
        req_valid = v; req_func = f; req_a = a; req_b = b;
        #1;
        e_stall = v && touches(f) && m_busy;
        e_rv    = v && (f == RU || f == RL) && !m_busy;
        e_data  = e_rv ? ((f == RU) ? m_up : m_lo) : 32'h0;
        skip    = e_rv && ((f == RU) ? m_uup : m_ulo);
        check_eq(cur_tag, "busy", {31'b0, busy}, {31'b0, m_busy});
        check_eq(cur_tag, "req_stall", {31'b0, req_stall}, {31'b0, e_stall});
        check_eq(cur_tag, "rd_valid", {31'b0, rd_valid}, {31'b0, e_rv});
        if (!skip) check_eq(cur_tag, "rd_data", rd_data, e_data);
    endtask

    task automatic idle();
        cyc(1'b0, 6'b0, 32'h0, 32'h0);
    endtask

    // Read one register while idle and compare with a literal
    task automatic read_expect(input logic up, input logic [31:0] exp, input string tag);
        cyc(1'b1, up ? RU : RL, 32'h0, 32'h0);
        check_eq(tag, up ? "upper read" : "lower read", rd_data, exp);
        check_eq(tag, "read accepted", {31'b0, rd_valid}, 32'h1);
    endtask

    // Start an operation and count the cycles busy stays high
    task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b, output int n);
        n = 0;
        cyc(1'b1, f, a, b);
        for (int i = 0; i < 100; i++) begin
            idle();
            if (busy) n++;
            else break;
        end
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        cur_tag = "R10";
        read_expect(1'b1, 32'h0, "R10");
        read_expect(1'b0, 32'h0, "R10");

        // R8: writes touch only their own register
        cur_tag = "R8";
        cyc(1'b1, WU, 32'h12345678, 32'h0);
        read_expect(1'b1, 32'h12345678, "R8");
        read_expect(1'b0, 32'h0, "R8");
        cyc(1'b1, WL, 32'hCAFEF00D, 32'h0);
        read_expect(1'b0, 32'hCAFEF00D, "R8");
        read_expect(1'b1, 32'h12345678, "R8");

        // R1 / R5: multiply results and latency
        cur_tag = "R1";
        run_op(MS, 32'd7, 32'hFFFFFFFD, n);
        check_eq("R5", "multiply busy cycles", n, MUL_LAT);
        read_expect(1'b0, 32'hFFFFFFEB, "R1");
        read_expect(1'b1, 32'hFFFFFFFF, "R1");
        run_op(MU, 32'hFFFFFFFF, 32'hFFFFFFFF, n);
        read_expect(1'b1, 32'hFFFFFFFE, "R1");
        read_expect(1'b0, 32'h00000001, "R1");
        run_op(MS, 32'hFFFFFFFF, 32'hFFFFFFFF, n);
        read_expect(1'b1, 32'h0, "R1");
        read_expect(1'b0, 32'h1, "R1");
        run_op(MU, 32'h00010000, 32'h00010000, n);
        read_expect(1'b1, 32'h1, "R1");
        read_expect(1'b0, 32'h0, "R1");

        // R2 / R5: divide results and latency
        cur_tag = "R2";
        run_op(DS, 32'hFFFFFFF9, 32'd2, n);
        check_eq("R5", "divide busy cycles", n, DIV_LAT);
        read_expect(1'b0, 32'hFFFFFFFD, "R2");
        read_expect(1'b1, 32'hFFFFFFFF, "R2");
        run_op(DS, 32'd7, 32'hFFFFFFFE, n);
        read_expect(1'b0, 32'hFFFFFFFD, "R2");
        read_expect(1'b1, 32'h1, "R2");
        run_op(DU, 32'hFFFFFFF9, 32'd2, n);
        read_expect(1'b0, 32'h7FFFFFFC, "R2");
        read_expect(1'b1, 32'h1, "R2");
        run_op(DU, 32'd100, 32'd7, n);
        read_expect(1'b0, 32'd14, "R2");
        read_expect(1'b1, 32'd2, "R2");

        // R4: signed wrap cases
        cur_tag = "R4";
        run_op(DS, 32'h80000000, 32'hFFFFFFFF, n);
        read_expect(1'b0, 32'h80000000, "R4");
        read_expect(1'b1, 32'h0, "R4");
        run_op(MS, 32'h80000000, 32'hFFFFFFFF, n);
        read_expect(1'b0, 32'h80000000, "R4");
        read_expect(1'b1, 32'h0, "R4");

        // R3: zero divisor
        cur_tag = "R3";
        run_op(DU, 32'd1234, 32'd0, n);
        check_eq("R3", "zero-divisor busy cycles", n, DIV_LAT);
        run_op(MU, 32'd3, 32'd5, n);
        check_eq("R3", "multiply after zero divisor cycles", n, MUL_LAT);
        read_expect(1'b0, 32'd15, "R3");
        read_expect(1'b1, 32'd0, "R3");

        // R6: read stalls while busy, then returns the new value
        cur_tag = "R6";
        cyc(1'b1, MU, 32'd6, 32'd7);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            cyc(1'b1, RL, 32'h0, 32'h0);
            if (req_stall) begin
                n++;
                check_eq("R6", "rd_valid while stalled", {31'b0, rd_valid}, 32'h0);
            end else break;
        end
        check_eq("R6", "stalled read cycles", n, MUL_LAT);
        check_eq("R6", "first read after completion", rd_data, 32'd42);

        // R7: a second start while busy is held off
        cur_tag = "R7";
        cyc(1'b1, DU, 32'd50, 32'd8);
        n = 0;
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, MU, 32'd9, 32'd9);
            if (busy) n++;
        end
        for (int i = 0; i < 100; i++) begin
            idle();
            if (busy) n++;
            else break;
        end
        check_eq("R7", "busy cycles with competing start", n, DIV_LAT);
        read_expect(1'b0, 32'd6, "R7");
        read_expect(1'b1, 32'd2, "R7");

        // R9: unrelated function codes never stall or disturb
        cur_tag = "R9";
        cyc(1'b1, DS, 32'hFFFFFF9C, 32'd7);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            cyc(1'b1, (i % 2 == 0) ? 6'b100000 : 6'b000000, 32'hDEADBEEF, 32'h1);
            if (req_stall) n++;
            if (!busy) break;
        end
        check_eq("R9", "stalls on unrelated codes", n, 0);
        read_expect(1'b0, 32'hFFFFFFF2, "R9");
        read_expect(1'b1, 32'hFFFFFFFE, "R9");
        cyc(1'b1, 6'b100001, 32'h55555555, 32'h0);
        check_eq("R9", "busy after unrelated code", {31'b0, busy}, 32'h0);
        read_expect(1'b0, 32'hFFFFFFF2, "R9");
        read_expect(1'b1, 32'hFFFFFFFE, "R9");

        // R8: write while busy waits, then overwrites only its target
        cur_tag = "R8";
        cyc(1'b1, MU, 32'd2, 32'd3);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            cyc(1'b1, WU, 32'hAAAA5555, 32'h0);
            if (req_stall) n++;
            else break;
        end
        check_eq("R8", "stalled write cycles", n, MUL_LAT);
        read_expect(1'b1, 32'hAAAA5555, "R8");
        read_expect(1'b0, 32'd6, "R8");

        idle();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule